// File: doc/BRIEF.md
# Handshake Shift Transfer Engine

This block is the peripheral half of a three-wire byte handshake. A host moves packets through one shared 8-bit shift register. It drives two active-low port-B lines, acknowledge and in-progress, and reads back an active-low request line. A direction bit chooses the flow. With the bit set, bytes flow from the host to the controller and collect in an outbound buffer. With it clear, bytes from a previously loaded response packet are presented one at a time on the shift register read value. The block does not step bytes on a clock. It steps a byte on each port-B update whose acknowledge/in-progress pair differs from the pair seen at the previous update.

The handshake phase is held in an enumerated register with three states: `PH_IDLE` (in-progress inactive), `PH_RECV` (host-to-controller transfer active) and `PH_SEND` (controller-to-host transfer active). On every port-B update the phase moves as follows:
- to `PH_IDLE` when in-progress is high;
- to `PH_RECV` when in-progress is low and the direction bit is set;
- to `PH_SEND` when in-progress is low and the direction bit is clear.

There are two idle-side transitions. An update with in-progress high that leaves `PH_RECV` or `PH_SEND` ends the transfer. An update in `PH_IDLE` where only acknowledge moves is the sync case, and request copies acknowledge.

Every byte step, end of transfer, sync update and response load schedules a shift-complete interrupt. A second process, the delay timer, handles the interrupt. It goes `TM_IDLE` to `TM_RUN` on a schedule, reloads while in `TM_RUN` on a new schedule, and returns to `TM_IDLE` when it fires one pulse after the programmed delay. At the end of each host packet the engine reports its byte count. It also pulses strobes that let a background poller pause while a host packet is arriving and resume once the host has drained a response.

Top module: `hsx_engine`

## Requirements
- R1: After reset, req_n is 1, and sr_irq, pkt_done, poll_block and poll_unblock are 0, and sr_rdata is 0. Reset also clears both indices and the inbound size, and sets the phase to `PH_IDLE`. The stored port-B pair resets to {ack_n,tip_n} = 2'b11.
- R2: While portb_tip_n is 0 and dir_out is 1, a port-B update stores sr_wdata at the next outbound index, but only if its {ack_n,tip_n} pair differs from the pair of the previous update. An update with an unchanged pair stores nothing.
- R3: The outbound buffer holds DEPTH (16) bytes. Host-to-controller steps that arrive once it is full are dropped, and the bytes already stored are not changed.
- R4: poll_block is a one-cycle pulse in the cycle after the step that stores the first byte of an outbound packet. Later steps do not pulse it.
- R5: An update with portb_tip_n 1 that leaves `PH_RECV` or `PH_SEND` ends the transfer. If the outbound count is nonzero, pkt_done pulses for one cycle and pkt_len holds that count. The count then returns to zero, so the next packet starts at index 0. If the count is zero, no pkt_done is raised.
- R6: While portb_tip_n is 0 and dir_out is 0, a changed-pair update loads the next unread inbound byte onto sr_rdata, but only while unread bytes remain. The update that loads the last byte also sets req_n to 1 and pulses poll_unblock for one cycle. Further steps leave sr_rdata unchanged.
- R7: When in-progress is high at both the previous and the current update and portb_ack_n changes, req_n takes the new portb_ack_n level.
- R8: An idle update that is not a sync update drives req_n to 0 while unread inbound bytes remain. A response load made in `PH_IDLE` with a nonzero length also drives req_n to 0.
- R9: Each byte step, end of transfer, sync update and response load schedules sr_irq. sr_irq is a one-cycle pulse that goes high DELAY_US*CLK_MHZ clock cycles after the cycle that scheduled it.
- R10: A new schedule that arrives while a delay is still counting restarts the countdown. Only one sr_irq pulse results, timed from the latest schedule.
- R11: rsp_load sets the inbound index to 0 and the inbound size to rsp_len, limited to DEPTH. Inbound bytes are first written with rsp_we/rsp_waddr/rsp_wdata. rsp_load and portb_wr are never asserted in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| portb_wr | input | 1 | One-cycle strobe: port-B has been updated by the host |
| portb_ack_n | input | 1 | Acknowledge level, active low |
| portb_tip_n | input | 1 | Transfer-in-progress level, active low |
| dir_out | input | 1 | Shift direction: 1 host-to-controller, 0 controller-to-host |
| sr_wdata | input | 8 | Shift register value written by the host |
| req_n | output | 1 | Request line to the host, active low |
| sr_rdata | output | 8 | Shift register value presented to the host |
| sr_irq | output | 1 | Delayed shift-complete interrupt pulse |
| rsp_we | input | 1 | Write enable for the inbound (response) buffer |
| rsp_waddr | input | AW (4) | Inbound buffer write address |
| rsp_wdata | input | 8 | Inbound buffer write data |
| rsp_load | input | 1 | Start presenting a response of rsp_len bytes |
| rsp_len | input | CW (5) | Response length in bytes |
| pkt_done | output | 1 | One-cycle pulse: a host packet has completed |
| pkt_len | output | CW (5) | Byte count of the completed host packet |
| obuf_raddr | input | AW (4) | Outbound buffer read address |
| obuf_rdata | output | 8 | Outbound buffer byte at obuf_raddr |
| poll_block | output | 1 | Pulse: first byte of a host packet stored |
| poll_unblock | output | 1 | Pulse: last response byte handed to the host |

## Verification
On every cycle, the assertions check the following:
- the outbound count never exceeds the buffer depth;
- an unchanged port-B pair never moves the outbound count;
- poll_block appears only with a count of one;
- pkt_done carries a nonzero length and a cleared count;
- poll_unblock coincides with an inactive request and an exhausted response;
- sr_irq is a single pulse that comes out of a running countdown.

Only the bench scenarios can show the rest:
- byte contents and their order in both directions;
- the request level in the sync and pending-data cases;
- the exact delay of the interrupt;
- the restart of an interrupt that is already pending;
- the clamping of an oversize response length.

// File: rtl/hsx_pkg.sv
`timescale 1ns/1ps
package hsx_pkg;

    // Handshake phase, tracking the in-progress level and direction seen at the last update
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_RECV = 2'd1,
        PH_SEND = 2'd2
    } phase_e;

    // Interrupt delay timer state
    typedef enum logic {
        TM_IDLE = 1'b0,
        TM_RUN  = 1'b1
    } tmr_e;

endpackage

// File: rtl/hsx_byte_buf.sv
`timescale 1ns/1ps
module hsx_byte_buf #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);

    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/hsx_irq_delay.sv
`timescale 1ns/1ps
module hsx_irq_delay import hsx_pkg::*; #(
    parameter int DELAY_CYC = 2000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic irq
);

    localparam int CNTW = $clog2(DELAY_CYC + 1);
    localparam logic [CNTW-1:0] LOAD = CNTW'(DELAY_CYC);
    localparam logic [CNTW-1:0] ONE  = CNTW'(1);

    tmr_e            st, st_nx;
    logic [CNTW-1:0] cnt, cnt_nx;
    logic            fire;

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        fire   = 1'b0;
        if (kick) begin
            st_nx  = TM_RUN;
            cnt_nx = LOAD;
        end else begin
            unique case (st)
                TM_IDLE: begin
                    cnt_nx = '0;
                end
                TM_RUN: begin
                    if (cnt == ONE) begin
                        st_nx  = TM_IDLE;
                        cnt_nx = '0;
                        fire   = 1'b1;
                    end else begin
                        cnt_nx = cnt - ONE;
                    end
                end
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= TM_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= fire;
        end
    end

    // R10: one pulse per expiry
    a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    // R9: a pulse only ever follows a running countdown
    a_r9_from_count: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(st) == TM_RUN);

endmodule

// File: rtl/hsx_engine.sv
`timescale 1ns/1ps
module hsx_engine import hsx_pkg::*; #(
    parameter int DEPTH    = 16,
    parameter int CLK_MHZ  = 100,
    parameter int DELAY_US = 20,
    localparam int AW      = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW      = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          portb_wr,
    input  logic          portb_ack_n,
    input  logic          portb_tip_n,
    input  logic          dir_out,
    input  logic [7:0]    sr_wdata,
    output logic          req_n,
    output logic [7:0]    sr_rdata,
    output logic          sr_irq,
    input  logic          rsp_we,
    input  logic [AW-1:0] rsp_waddr,
    input  logic [7:0]    rsp_wdata,
    input  logic          rsp_load,
    input  logic [CW-1:0] rsp_len,
    output logic          pkt_done,
    output logic [CW-1:0] pkt_len,
    input  logic [AW-1:0] obuf_raddr,
    output logic [7:0]    obuf_rdata,
    output logic          poll_block,
    output logic          poll_unblock
);

    localparam int DELAY_CYC = CLK_MHZ * DELAY_US;
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);
    localparam logic [CW-1:0] ONE_C   = CW'(1);

    phase_e        phase, phase_nx;
    logic [1:0]    hs_last;
    logic [1:0]    hs_now;
    logic [CW-1:0] out_cnt;
    logic [CW-1:0] in_idx;
    logic [CW-1:0] in_size;
    logic [CW-1:0] rsp_len_c;
    logic [7:0]    ibuf_rdata;

    logic hs_changed, active, out_room, in_left, in_last;
    logic step_rx, step_tx, sync_ev, end_ev, idle_upd, sched;

    // ---------------------------------------------------------------
    // Event decode for one port-B update
    // ---------------------------------------------------------------
    assign hs_now     = {portb_ack_n, portb_tip_n};
    assign hs_changed = (hs_now != hs_last);
    assign active     = !portb_tip_n;
    assign out_room   = (out_cnt < DEPTH_C);
    assign in_left    = (in_idx < in_size);
    assign in_last    = ((in_idx + ONE_C) >= in_size);
    assign rsp_len_c  = (rsp_len > DEPTH_C) ? DEPTH_C : rsp_len;

    assign step_rx  = portb_wr && active && dir_out && hs_changed && out_room;
    assign step_tx  = portb_wr && active && !dir_out && hs_changed && in_left;
    assign sync_ev  = portb_wr && !active && (phase == PH_IDLE)
                      && (portb_ack_n != hs_last[1]);
    assign end_ev   = portb_wr && !active && (phase != PH_IDLE);
    assign idle_upd = portb_wr && !active && !sync_ev;
    assign sched    = step_rx || step_tx || sync_ev || end_ev || rsp_load;

    // ---------------------------------------------------------------
    // Phase: next-state logic and state register
    // ---------------------------------------------------------------
    always_comb begin
        phase_nx = phase;
        if (portb_wr) begin
            unique case (phase)
                PH_IDLE, PH_RECV, PH_SEND: begin
                    if (!active)      phase_nx = PH_IDLE;
                    else if (dir_out) phase_nx = PH_RECV;
                    else              phase_nx = PH_SEND;
                end
                default: phase_nx = PH_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            hs_last <= 2'b11;
        end else begin
            phase <= phase_nx;
            if (portb_wr) hs_last <= hs_now;
        end
    end

    // ---------------------------------------------------------------
    // Counters and outputs
    // ---------------------------------------------------------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_n        <= 1'b1;
            sr_rdata     <= '0;
            out_cnt      <= '0;
            in_idx       <= '0;
            in_size      <= '0;
            pkt_done     <= 1'b0;
            pkt_len      <= '0;
            poll_block   <= 1'b0;
            poll_unblock <= 1'b0;
        end else begin
            pkt_done     <= 1'b0;
            poll_block   <= 1'b0;
            poll_unblock <= 1'b0;

            if (step_rx) begin
                out_cnt    <= out_cnt + ONE_C;
                poll_block <= (out_cnt == '0);
            end

            if (step_tx) begin
                sr_rdata <= ibuf_rdata;
                in_idx   <= in_idx + ONE_C;
                if (in_last) begin
                    req_n        <= 1'b1;
                    poll_unblock <= 1'b1;
                end
            end

            if (sync_ev) begin
                req_n <= portb_ack_n;
            end else if (idle_upd && in_left) begin
                req_n <= 1'b0;
            end

            if (end_ev) begin
                pkt_done <= (out_cnt != '0);
                pkt_len  <= out_cnt;
                out_cnt  <= '0;
            end

            if (rsp_load) begin
                in_idx  <= '0;
                in_size <= rsp_len_c;
                if ((phase == PH_IDLE) && (rsp_len_c != '0)) req_n <= 1'b0;
            end
        end
    end

    // ---------------------------------------------------------------
    // Storage and interrupt timer
    // ---------------------------------------------------------------
    hsx_byte_buf #(.DEPTH(DEPTH), .W(8)) u_obuf (
        .clk   (clk),
        .we    (step_rx),
        .waddr (out_cnt[AW-1:0]),
        .wdata (sr_wdata),
        .raddr (obuf_raddr),
        .rdata (obuf_rdata)
    );

    hsx_byte_buf #(.DEPTH(DEPTH), .W(8)) u_ibuf (
        .clk   (clk),
        .we    (rsp_we),
        .waddr (rsp_waddr),
        .wdata (rsp_wdata),
        .raddr (in_idx[AW-1:0]),
        .rdata (ibuf_rdata)
    );

    hsx_irq_delay #(.DELAY_CYC(DELAY_CYC)) u_delay (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (sched),
        .irq   (sr_irq)
    );

    // ---------------------------------------------------------------
    // Assertions
    // ---------------------------------------------------------------
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        out_cnt <= DEPTH_C);

    a_r2_unchanged_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        (portb_wr && (hs_now == hs_last)) |=> $stable(out_cnt));

    a_r4_block_first: assert property (@(posedge clk) disable iff (!rst_n)
        poll_block |-> (out_cnt == ONE_C));

    a_r5_len_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        pkt_done |-> ((pkt_len != '0) && (out_cnt == '0)));

    a_r6_unblock_req: assert property (@(posedge clk) disable iff (!rst_n)
        poll_unblock |-> (req_n && (in_idx == in_size)));

    a_r11_load_index: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_load |=> ((in_idx == '0) && (in_size <= DEPTH_C)));

    a_r11_no_collision: assert property (@(posedge clk) disable iff (!rst_n)
        !(rsp_load && portb_wr));

endmodule

// File: tb/hsx_engine_test.sv
`timescale 1ns/1ps
module hsx_engine_test;

    localparam int DEPTH = 16;
    localparam int DLY   = 6;
    localparam int AW    = 4;
    localparam int CW    = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          portb_wr = 1'b0;
    logic          portb_ack_n = 1'b1;
    logic          portb_tip_n = 1'b1;
    logic          dir_out = 1'b0;
    logic [7:0]    sr_wdata = '0;
    logic          req_n;
    logic [7:0]    sr_rdata;
    logic          sr_irq;
    logic          rsp_we = 1'b0;
    logic [AW-1:0] rsp_waddr = '0;
    logic [7:0]    rsp_wdata = '0;
    logic          rsp_load = 1'b0;
    logic [CW-1:0] rsp_len = '0;
    logic          pkt_done;
    logic [CW-1:0] pkt_len;
    logic [AW-1:0] obuf_raddr = '0;
    logic [7:0]    obuf_rdata;
    logic          poll_block;
    logic          poll_unblock;

    int n_run = 0;
    int n_fail = 0;
    bit reported = 1'b0;

    always #5 clk = ~clk;

    hsx_engine #(.DEPTH(DEPTH), .CLK_MHZ(1), .DELAY_US(DLY)) uut (
        .clk(clk), .rst_n(rst_n), .portb_wr(portb_wr), .portb_ack_n(portb_ack_n),
        .portb_tip_n(portb_tip_n), .dir_out(dir_out), .sr_wdata(sr_wdata),
        .req_n(req_n), .sr_rdata(sr_rdata), .sr_irq(sr_irq), .rsp_we(rsp_we),
        .rsp_waddr(rsp_waddr), .rsp_wdata(rsp_wdata), .rsp_load(rsp_load),
        .rsp_len(rsp_len), .pkt_done(pkt_done), .pkt_len(pkt_len),
        .obuf_raddr(obuf_raddr), .obuf_rdata(obuf_rdata),
        .poll_block(poll_block), .poll_unblock(poll_unblock)
    );

    // Read-side table: {ack_n, tip_n, exp_req_n, exp_unblock, exp_rdata}
    localparam logic [11:0] VEC [8] = '{
        {1'b1, 1'b0, 1'b0, 1'b0, 8'hA1},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'hB2},
        {1'b0, 1'b0, 1'b0, 1'b0, 8'hB2},
        {1'b1, 1'b0, 1'b1, 1'b1, 8'hC3},
        {1'b0, 1'b0, 1'b1, 1'b0, 8'hC3},
        {1'b1, 1'b1, 1'b1, 1'b0, 8'hC3},
        {1'b0, 1'b1, 1'b0, 1'b0, 8'hC3},
        {1'b1, 1'b1, 1'b1, 1'b0, 8'hC3}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        end
        $finish;
    endtask

    task automatic pb(input logic ack, input logic tip);
        @(negedge clk);
        portb_ack_n = ack;
        portb_tip_n = tip;
        portb_wr    = 1'b1;
        @(negedge clk);
        portb_wr    = 1'b0;
    endtask

    task automatic wr_rsp(input int a, input logic [7:0] d);
        @(negedge clk);
        rsp_we    = 1'b1;
        rsp_waddr = AW'(a);
        rsp_wdata = d;
        @(negedge clk);
        rsp_we    = 1'b0;
    endtask

    task automatic load_rsp(input int len);
        @(negedge clk);
        rsp_load = 1'b1;
        rsp_len  = CW'(len);
        @(negedge clk);
        rsp_load = 1'b0;
    endtask

    task automatic rd_obuf(input int a, input logic [7:0] exp, input string req);
        obuf_raddr = AW'(a);
        #1;
        chk(req, 32'(obuf_rdata), 32'(exp));
    endtask

    task automatic quiet();
        repeat (DLY + 4) @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int pulses;
        int first_at;

        // R1: reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 req_n", 32'(req_n), 32'd1);
        chk("R1 sr_irq", 32'(sr_irq), 32'd0);
        chk("R1 pkt_done", 32'(pkt_done), 32'd0);
        chk("R1 sr_rdata", 32'(sr_rdata), 32'd0);
        chk("R1 poll strobes", 32'({poll_block, poll_unblock}), 32'd0);

        // R11/R8: response load raises request in idle
        dir_out = 1'b0;
        wr_rsp(0, 8'hA1);
        wr_rsp(1, 8'hB2);
        wr_rsp(2, 8'hC3);
        load_rsp(3);
        chk("R8 req after load", 32'(req_n), 32'd0);

        // R6/R7 table walk: controller-to-host read, end, sync
        for (int i = 0; i < 8; i++) begin
            pb(VEC[i][11], VEC[i][10]);
            chk($sformatf("R6 rdata step %0d", i), 32'(sr_rdata), 32'(VEC[i][7:0]));
            chk($sformatf("R7 req_n step %0d", i), 32'(req_n), 32'(VEC[i][9]));
            chk($sformatf("R6 unblock step %0d", i), 32'(poll_unblock), 32'(VEC[i][8]));
            if (i == 5) chk("R5 no pkt on empty", 32'(pkt_done), 32'd0);
        end

        // R2/R4/R5: host-to-controller packet with one repeated pair
        quiet();
        dir_out = 1'b1;
        sr_wdata = 8'h11; pb(1'b1, 1'b0);
        chk("R4 block on first", 32'(poll_block), 32'd1);
        sr_wdata = 8'h22; pb(1'b0, 1'b0);
        chk("R4 no block later", 32'(poll_block), 32'd0);
        sr_wdata = 8'h99; pb(1'b0, 1'b0);
        sr_wdata = 8'h33; pb(1'b1, 1'b0);
        pb(1'b1, 1'b1);
        chk("R5 pkt_done", 32'(pkt_done), 32'd1);
        chk("R2 pkt_len skips repeat", 32'(pkt_len), 32'd3);
        rd_obuf(0, 8'h11, "R2 byte0");
        rd_obuf(1, 8'h22, "R2 byte1");
        rd_obuf(2, 8'h33, "R2 byte2");
        @(negedge clk);
        chk("R5 pkt_done one cycle", 32'(pkt_done), 32'd0);

        // R3: overflow past 16 bytes
        for (int i = 0; i < 20; i++) begin
            sr_wdata = 8'(8'h40 + i);
            pb((i % 2 == 0) ? 1'b1 : 1'b0, 1'b0);
        end
        pb(1'b1, 1'b1);
        chk("R3 len capped", 32'(pkt_len), 32'd16);
        rd_obuf(0, 8'h40, "R3 first kept");
        rd_obuf(15, 8'h4F, "R3 last kept");

        // R5: count cleared, next packet restarts at index 0
        sr_wdata = 8'h77; pb(1'b1, 1'b0);
        pb(1'b1, 1'b1);
        chk("R5 next len", 32'(pkt_len), 32'd1);
        rd_obuf(0, 8'h77, "R5 restart index");

        // R9: end of an empty transfer still schedules the interrupt
        quiet();
        dir_out = 1'b0;
        pb(1'b1, 1'b0);
        quiet();
        chk("R9 no irq without event", 32'(sr_irq), 32'd0);
        pb(1'b1, 1'b1);
        chk("R5 empty no pkt", 32'(pkt_done), 32'd0);
        repeat (DLY - 1) @(negedge clk);
        chk("R9 irq not early", 32'(sr_irq), 32'd0);
        @(negedge clk);
        chk("R9 irq on time", 32'(sr_irq), 32'd1);
        @(negedge clk);
        chk("R9 irq one cycle", 32'(sr_irq), 32'd0);

        // R10 and R7: two sync updates, restart of the countdown
        quiet();
        pb(1'b0, 1'b1);
        chk("R7 req follows ack low", 32'(req_n), 32'd0);
        repeat (3) @(negedge clk);
        pb(1'b1, 1'b1);
        chk("R7 req follows ack high", 32'(req_n), 32'd1);
        pulses = 0;
        first_at = -1;
        for (int c = 1; c <= 12; c++) begin
            @(negedge clk);
            if (sr_irq) begin
                pulses++;
                if (first_at < 0) first_at = c;
            end
        end
        chk("R10 single pulse", 32'(pulses), 32'd1);
        chk("R10 timed from last", 32'(first_at), 32'(DLY));

        // R8: idle update with bytes still unread pulls request low
        wr_rsp(0, 8'h5A);
        wr_rsp(1, 8'h6B);
        load_rsp(2);
        pb(1'b1, 1'b0);
        chk("R6 partial byte", 32'(sr_rdata), 32'h5A);
        pb(1'b1, 1'b1);
        chk("R8 req pending", 32'(req_n), 32'd0);

        // R11: oversize length clamps to DEPTH
        for (int i = 0; i < 16; i++) wr_rsp(i, 8'(8'h80 + i));
        load_rsp(20);
        for (int i = 0; i < 16; i++) begin
            pb((i % 2 == 0) ? 1'b0 : 1'b1, 1'b0);
            if (i == 14) chk("R11 req before last", 32'(req_n), 32'd0);
        end
        chk("R11 last byte", 32'(sr_rdata), 32'h8F);
        chk("R11 req after 16", 32'(req_n), 32'd1);
        chk("R11 unblock after 16", 32'(poll_unblock), 32'd1);
        pb(1'b0, 1'b0);
        chk("R6 exhausted hold", 32'(sr_rdata), 32'h8F);

        // R1: reset in mid state
        pb(1'b1, 1'b1);
        wr_rsp(0, 8'h01);
        load_rsp(1);
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 req after reset", 32'(req_n), 32'd1);
        chk("R1 rdata after reset", 32'(sr_rdata), 32'd0);
        rst_n = 1'b1;

        report();
    end

endmodule